// File: doc/BRIEF.md
# Time-Shared Complex Quotient Sequencer

This block forms the complex quotient Qre + j·Qim from three real operands produced upstream: the numerator of the real part, the numerator of the imaginary part, and the common denominator (the squared magnitude of the divisor). It does not divide by itself. A single external division unit sits behind a start/done handshake. The sequencer runs that unit twice, first for the real part and then for the imaginary part, so one divider can serve where two would otherwise be needed.

A request is accepted with a one-cycle `start` while the block is idle. The three operands are captured at that point. An operand multiplexer steered by a part-select line feeds the divider. A result demultiplexer steers each returned quotient into its own hold register. Both parts appear on the outputs in the same cycle, marked by a one-cycle `done`. The block also reports three flags: a zero flag for each part and an infinity flag for a zero denominator.

Numerators are signed W-bit two's complement values. The denominator is an unsigned W-bit value. Quotients are signed QW-bit fixed-point values with FRAC fractional bits, returned by the divider truncated toward zero.

Top module: `cplx_quot_seq`

## Requirements
- R1: Reset holds the block in its idle state. While reset is applied and after it is released, busy, done, div_start, part_sel, every flag and both quotient outputs read 0.
- R2: A start seen while idle is accepted. In the next cycle busy is 1 and div_start is 1 for exactly one cycle, with part_sel=0, div_num equal to the captured real numerator and div_den equal to the captured denominator.
- R3: The cycle after the first div_done, part_sel goes to 1 and a second one-cycle div_start is issued, with div_num equal to the captured imaginary numerator and the same denominator.
- R4: Each operation issues exactly two div_start pulses.
- R5: The cycle after the second div_done, q_re and q_im both take their new values and done is 1 for exactly one cycle. The quotient outputs do not change in any other cycle.
- R6: q_re is the quotient returned by the first division and q_im is the quotient returned by the second division. For example, with a divider that truncates toward zero and FRAC=8, operands (4, -3, 5) give q_re=204 and q_im=-153, which is 0.8 - 0.6j.
- R7: Changes on num_re, num_im or den after a start has been accepted do not affect the operation that is running.
- R8: A start that arrives while busy is ignored. It adds no div_start and does not alter the result.
- R9: When done is 1, zero_re is 1 exactly when the first quotient was 0 and zero_im is 1 exactly when the second quotient was 0. inf is 1 exactly when the captured denominator was 0. All three flags are 0 when both quotients and the denominator are nonzero.
- R10: A div_done that arrives while idle is ignored. It leaves busy at 0, raises no done and does not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| num_re | input | W | Signed real-part numerator |
| num_im | input | W | Signed imaginary-part numerator |
| den | input | W | Unsigned common denominator |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: new quotients and flags are valid |
| q_re | output | QW | Real quotient, signed fixed point |
| q_im | output | QW | Imaginary quotient, signed fixed point |
| zero_re | output | 1 | Real quotient was zero |
| zero_im | output | 1 | Imaginary quotient was zero |
| inf | output | 1 | Denominator was zero |
| part_sel | output | 1 | 0 while the real part is in the divider, 1 while the imaginary part is in it |
| div_start | output | 1 | Start pulse to the shared divider |
| div_num | output | W | Numerator routed to the divider |
| div_den | output | W | Denominator routed to the divider |
| div_done | input | 1 | Divider completion pulse |
| div_quo | input | QW | Divider quotient, valid with div_done |

## Verification
The assertions rely on the divider being well behaved. It must raise div_done for one cycle, exactly once per div_start, and never in the same cycle as the start it answers. The environment must not raise start during reset. The bench's behavioural divider enforces this by waiting a pseudo-random latency of one to eight cycles before it answers. A stray div_done is injected only while the block is idle, where R10 requires it to be ignored. The bench sweeps numerators across a small signed range and denominators from zero upward, and it scrambles the operands during each run.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN_RE = 2'd1,
    ST_RUN_IM = 2'd2,
    ST_DONE   = 2'd3
  } cq_state_e;
endpackage

// File: rtl/cq_seq_fsm.sv
module cq_seq_fsm
  import cq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      div_done,
  output cq_state_e state,
  output logic      sel,
  output logic      div_start,
  output logic      accept,
  output logic      take_re,
  output logic      take_im
);
  assign accept  = (state == ST_IDLE) && start;
  assign take_re = (state == ST_RUN_RE) && div_done;
  assign take_im = (state == ST_RUN_IM) && div_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sel       <= 1'b0;
      div_start <= 1'b0;
    end else begin
      div_start <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_RUN_RE;
          sel       <= 1'b0;
          div_start <= 1'b1;
        end
        ST_RUN_RE: if (div_done) begin
          state     <= ST_RUN_IM;
          sel       <= 1'b1;
          div_start <= 1'b1;
        end
        ST_RUN_IM: if (div_done) state <= ST_DONE;
        ST_DONE: begin
          state <= ST_IDLE;
          sel   <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: every divider start lasts a single cycle
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    div_start |=> !div_start);
  // R2: a divider start is only issued while a part is in flight
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    div_start |-> (state == ST_RUN_RE || state == ST_RUN_IM));
  // R3: the select line rises only after the real part has returned
  assert_sel_order_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sel) |-> ($past(state) == ST_RUN_RE && $past(div_done)));
  // R10: a completion while idle without a request keeps the block idle
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && div_done && !start) |=> state == ST_IDLE);
endmodule

// File: rtl/cq_operand_mux.sv
module cq_operand_mux #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] op_re,
  input  logic [W-1:0] op_im,
  input  logic [W-1:0] op_den,
  output logic [W-1:0] div_num,
  output logic [W-1:0] div_den
);
  always_comb begin
    div_num = sel ? op_im : op_re;
    div_den = op_den;
  end
endmodule

// File: rtl/cq_result_demux.sv
module cq_result_demux #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_re,
  input  logic          take_im,
  input  logic [QW-1:0] quo,
  output logic [QW-1:0] q_re,
  output logic [QW-1:0] q_im,
  output logic          zero_re,
  output logic          zero_im
);
  logic [QW-1:0] hold_re;
  logic          hold_zre;
  logic          quo_zero;

  assign quo_zero = (quo == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_re  <= '0;
      hold_zre <= 1'b0;
      q_re     <= '0;
      q_im     <= '0;
      zero_re  <= 1'b0;
      zero_im  <= 1'b0;
    end else begin
      if (take_re) begin
        hold_re  <= quo;
        hold_zre <= quo_zero;
      end
      if (take_im) begin
        q_re    <= hold_re;
        zero_re <= hold_zre;
        q_im    <= quo;
        zero_im <= quo_zero;
      end
    end
  end

  // R5: the visible quotients change only on the second completion
  assert_out_update_R5: assert property (@(posedge clk) disable iff (rst)
    (q_re != $past(q_re) || q_im != $past(q_im)) |-> $past(take_im));
  // R4: the two halves never complete in the same cycle
  assert_one_take_R4: assert property (@(posedge clk) disable iff (rst)
    !(take_re && take_im));
endmodule

// File: rtl/cplx_quot_seq.sv
module cplx_quot_seq
  import cq_pkg::*;
#(
  parameter int W    = 8,
  parameter int FRAC = 8,
  parameter int QW   = W + FRAC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  num_re,
  input  logic [W-1:0]  num_im,
  input  logic [W-1:0]  den,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] q_re,
  output logic [QW-1:0] q_im,
  output logic          zero_re,
  output logic          zero_im,
  output logic          inf,
  output logic          part_sel,
  output logic          div_start,
  output logic [W-1:0]  div_num,
  output logic [W-1:0]  div_den,
  input  logic          div_done,
  input  logic [QW-1:0] div_quo
);
  cq_state_e    state;
  logic         accept, take_re, take_im;
  logic [W-1:0] op_re, op_im, op_den;
  logic         inf_cap;

  cq_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .div_done(div_done),
    .state(state), .sel(part_sel), .div_start(div_start),
    .accept(accept), .take_re(take_re), .take_im(take_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_re   <= '0;
      op_im   <= '0;
      op_den  <= '0;
      inf_cap <= 1'b0;
      inf     <= 1'b0;
    end else begin
      if (accept) begin
        op_re   <= num_re;
        op_im   <= num_im;
        op_den  <= den;
        inf_cap <= (den == '0);
      end
      if (take_im) inf <= inf_cap;
    end
  end

  cq_operand_mux #(.W(W)) u_mux (
    .sel(part_sel), .op_re(op_re), .op_im(op_im), .op_den(op_den),
    .div_num(div_num), .div_den(div_den)
  );

  cq_result_demux #(.QW(QW)) u_demux (
    .clk(clk), .rst(rst), .take_re(take_re), .take_im(take_im), .quo(div_quo),
    .q_re(q_re), .q_im(q_im), .zero_re(zero_re), .zero_im(zero_im)
  );

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // R5: done lasts exactly one cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: the infinity flag reflects the denominator seen at acceptance
  assert_inf_capture_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (inf_cap == ($past(den) == '0)));
  // R7: the routed denominator stays fixed while a part is in flight
  assert_den_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(div_den));
endmodule

// File: tb/tb_cplx_quot_seq.sv
module tb_cplx_quot_seq;
  localparam int W = 8, FRAC = 8, QW = W + FRAC;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [W-1:0] num_re = '0, num_im = '0, den = '0;
  logic busy, done, zero_re, zero_im, inf, part_sel, div_start;
  logic [QW-1:0] q_re, q_im, div_quo;
  logic [W-1:0] div_num, div_den;
  logic model_done = 1'b0, stray = 1'b0, div_done;
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;
  assign div_done = model_done | stray;

  cplx_quot_seq #(.W(W), .FRAC(FRAC), .QW(QW)) dut (
    .clk(clk), .rst(rst), .start(start), .num_re(num_re), .num_im(num_im),
    .den(den), .busy(busy), .done(done), .q_re(q_re), .q_im(q_im),
    .zero_re(zero_re), .zero_im(zero_im), .inf(inf), .part_sel(part_sel),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .div_done(div_done), .div_quo(div_quo));

  function automatic logic [QW-1:0] ref_div(input logic [W-1:0] n, input logic [W-1:0] d);
    int nn, dd;
    nn = int'($signed(n));
    dd = int'(d);
    if (dd == 0) return '0;
    return QW'((nn * (1 << FRAC)) / dd);
  endfunction

  // behavioural divider with pseudo-random latency
  logic [7:0] lfsr = 8'hA5;
  int wait_cnt = -1;
  logic [W-1:0] m_num, m_den;
  int nstarts = 0;
  logic [W-1:0] first_num, second_num, first_den, second_den;
  logic first_sel, second_sel;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    model_done <= 1'b0;
    if (div_start) begin
      m_num <= div_num; m_den <= div_den;
      wait_cnt <= 1 + int'(lfsr[2:0]);
      nstarts <= nstarts + 1;
      first_num <= second_num; first_den <= second_den; first_sel <= second_sel;
      second_num <= div_num; second_den <= div_den; second_sel <= part_sel;
    end else if (wait_cnt > 1) wait_cnt <= wait_cnt - 1;
    else if (wait_cnt == 1) begin
      wait_cnt <= -1;
      model_done <= 1'b1;
      div_quo <= ref_div(m_num, m_den);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] d, input bit extra);
    int s0, t;
    logic [QW-1:0] er, ei;
    er = ref_div(a, d); ei = ref_div(b, d);
    @(negedge clk);
    num_re = a; num_im = b; den = d; start = 1'b1; s0 = nstarts;
    @(negedge clk);
    start = extra; num_re = ~a; num_im = a ^ b; den = d + 8'd3;   // R7, R8
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    check("R5 done seen", 32'(done), 32'd1);
    check("R6 q_re", 32'(q_re), 32'(er));
    check("R6 q_im", 32'(q_im), 32'(ei));
    check("R9 zero_re", 32'(zero_re), 32'(er == '0));
    check("R9 zero_im", 32'(zero_im), 32'(ei == '0));
    check("R9 inf", 32'(inf), 32'(d == '0));
    check("R4 start count", 32'(nstarts - s0), 32'd2);
    check("R2 first operand", {first_sel, first_den, first_num}, {1'b0, d, a});
    check("R3 second operand", {second_sel, second_den, second_num}, {1'b1, d, b});
    @(negedge clk);
    check("R5 done width", 32'(done), 32'd0);
    check("R5 outputs held", {q_re, q_im}, {er, ei});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {busy, done, div_start, part_sel, zero_re, zero_im, inf},
          7'd0);
    check("R1 reset quotients", {q_re, q_im}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {busy, done, div_start}, 3'd0);
    run_op(8'd4, 8'hFD, 8'd5, 1'b0);        // R6 directed: 0.8 - 0.6j
    check("R6 directed re", 32'(q_re), 32'd204);
    check("R6 directed im", 32'(q_im), 32'(16'hFF67));
    for (int a = -8; a < 8; a++)
      for (int bi = 0; bi < 3; bi++)
        for (int d = 0; d < 6; d++)
          run_op(W'(a), (bi == 0) ? 8'hF9 : (bi == 1) ? 8'd0 : 8'd5, W'(d), (a + d) % 2 == 0);
    // R10 stray completion while idle
    @(negedge clk); stray = 1'b1;
    @(negedge clk); stray = 1'b0;
    check("R10 busy stays low", 32'(busy), 32'd0);
    @(negedge clk);
    check("R10 no done", 32'(done), 32'd0);
    check("R10 outputs unchanged", {q_re, q_im}, {ref_div(8'd7, 8'd5), ref_div(8'd5, 8'd5)});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule